// File: doc/BRIEF.md
# SPI Master with Halfword Register Interface

This block is a serial peripheral master that software drives through eight 16-bit registers. Software places a word of up to 32 bits in two transmit halfwords, with the first bit to send at bit 31. It then writes a single control word that holds the bit count, a 3-bit target index and the transfer type, either send-only or send-and-receive. The block drives a mode-0 serial clock at half the functional clock rate. It pulls low the chip select of the addressed target for the whole transfer, shifts the word out most significant bit first and collects the return bits right-aligned. It then raises completion flags and, if they are not masked, an interrupt.

The receive flag does not rise when the last bit is taken. It follows a fixed settle interval after the send flag, so software that reads the receive halfwords once that flag is set always reads settled data. A control write is ignored while a transfer is in flight or while the serial clock is disabled.

Top module: `spim_ctrl`

## Requirements
- R1: After reset every register reads 0, all chip selects are high, SCLK and MOSI are low and the interrupt is low.
- R2: Registers are addressed by byte offset on reg_addr[3:1]: 0x00 setup (bit 0 clock enable, bit 4 send-only interrupt mask, bit 5 send-and-receive interrupt mask, other bits read 0), 0x02 a 16-bit spare setup word, 0x08 and 0x0A the low and high transmit halfwords. All of these read back what was written.
- R3: A write to 0x04 with bit 0 (send-and-receive) or bit 1 (send-only) set starts a transfer. Bits [6:2] give the length minus one (1 to 32 bits) and bits [9:7] give the target index. If both type bits are set, the transfer is send-and-receive.
- R4: SCLK idles low, runs at clk/2 and makes exactly one rising edge per bit. MOSI presents bits 31 down to 32-length of {TX high, TX low}, one per rising edge, and stays stable across each rising edge.
- R5: MISO is sampled on each SCLK rising edge. The receive word at 0x0E (high) and 0x0C (low) holds the received bits right-aligned, with the last bit at bit 0 and zeros above.
- R6: Target index 0 to 4 drives cs_n[index] low on every rising SCLK edge of the transfer, with the other selects high. Indices 5 to 7 select no target. All selects are high when the block is idle.
- R7: Status at 0x06: bit 1 (send done) rises when the final SCLK falling edge completes. For send-and-receive transfers, bit 0 (receive done) rises exactly SETTLE_CYC clock cycles later. For send-only transfers bit 0 stays 0.
- R8: Both status bits clear when a transfer starts.
- R9: A control write while a transfer is busy, or while the clock enable is 0, is ignored: no SCLK edges, no select and no status change.
- R10: irq is high when send done is set on a send-only transfer with bit 4 clear, or when receive done is set on a send-and-receive transfer with bit 5 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 5 | Active-low target selects |
| irq | output | 1 | Completion interrupt |

## Verification
A table of transfers covers the lengths 1, 5, 8, 13, 16, 24 and 32 with several different transmit and return patterns. This separates an off-by-one in the bit count, a shift in the wrong direction and an alignment error on either side. Each target index is used, and 6 is included to show that an out-of-range index selects no target. Send-only rows tell the two completion paths apart. Directed cases cover a start with the clock disabled, a second control write during a busy transfer, the exact settle gap, a control word with both type bits set and each interrupt mask against each transfer type.

// File: rtl/spim_pkg.sv
// Shared constants for the SPI master: register selects and control field positions.
package spim_pkg;
    localparam int XFER_W = 32;
    localparam int HALF_W = 16;
    localparam int LEN_W  = 5;
    localparam int DEV_W  = 3;
    localparam int CNT_W  = LEN_W + 1;

    // Control word field positions; software depends on these.
    localparam int C_RDWR = 0;
    localparam int C_WO   = 1;
    localparam int C_LEN  = 2;
    localparam int C_DEV  = C_LEN + LEN_W;
    localparam int C_TOP  = C_DEV + DEV_W - 1;

    typedef enum logic [2:0] {
        SEL_SETUP = 3'd0,
        SEL_SPARE = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_TXL   = 3'd4,
        SEL_TXH   = 3'd5,
        SEL_RXL   = 3'd6,
        SEL_RXH   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/spim_shift.sv
// Shift engine: mode-0 serial clock at clk/2, MSB-first out, shift-in on rising edge.
// Assumes start is only honoured while idle; len_m1 is length minus one.
module spim_shift #(
    parameter int XFER_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XFER_W-1:0] tx_word,
    input  logic [CNT_W-2:0]  len_m1,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [XFER_W-1:0] rx_word
);
    logic [XFER_W-1:0] tx_sh;
    logic [XFER_W-1:0] rx_sh;
    logic [CNT_W-1:0]  left;

    // Sequence the bit phases: rising edge samples, falling edge advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
            left  <= '0;
            sclk  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                tx_sh <= tx_word;
                rx_sh <= '0;
                left  <= {1'b0, len_m1} + CNT_W'(1);
                sclk  <= 1'b0;
            end else if (busy) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[XFER_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (left == CNT_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left  <= left - CNT_W'(1);
                        tx_sh <= {tx_sh[XFER_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi    = busy & tx_sh[XFER_W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spim_csdec.sv
// Chip-select decoder: one active-low select per valid index, none for out-of-range indices.
// Assumes dev is held stable while active is high.
module spim_csdec #(
    parameter int NUM_CS = 5,
    parameter int DEV_W  = 3
) (
    input  logic             active,
    input  logic [DEV_W-1:0] dev,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        // Drive select i low only while its index is being served.
        assign cs_n[i] = !(active && (dev == DEV_W'(i)));
    end
endmodule

// File: rtl/spim_status.sv
// Completion flags: send-done on engine done; receive-done after a settle interval
// for send-and-receive transfers; interrupt gated by per-type masks.
// Assumes SETTLE_CYC >= 1.
module spim_status #(
    parameter int SETTLE_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic rd_mode,
    input  logic mask_wo,
    input  logic mask_rw,
    output logic we_flag,
    output logic re_flag,
    output logic irq
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] settle;

    // Track the flags and count down the settle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_flag <= 1'b0;
            re_flag <= 1'b0;
            settle  <= '0;
        end else if (start) begin
            we_flag <= 1'b0;
            re_flag <= 1'b0;
            settle  <= '0;
        end else if (done) begin
            we_flag <= 1'b1;
            settle  <= rd_mode ? SW'(SETTLE_CYC) : '0;
        end else if (settle != '0) begin
            settle <= settle - SW'(1);
            if (settle == SW'(1)) re_flag <= 1'b1;
        end
    end

    assign irq = (we_flag && !rd_mode && !mask_wo) || (re_flag && rd_mode && !mask_rw);
endmodule

// File: rtl/spim_ctrl.sv
// SPI master top: halfword register file, start qualification, read mux.
// Assumes single-cycle register writes and combinational reads on reg_addr.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int NUM_CS     = 5,
    parameter int SETTLE_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    logic              clk_en, mask_wo, mask_rw;
    logic [HALF_W-1:0] spare, tx_lo, tx_hi;
    logic [C_TOP:0]    ctrl_q;
    logic              rd_mode;
    logic              busy, done, we_flag, re_flag, start;
    logic [XFER_W-1:0] rx_word;
    reg_sel_e          sel;

    assign sel   = reg_sel_e'(reg_addr[3:1]);
    assign start = reg_we && (sel == SEL_CTRL) && clk_en && !busy
                   && (reg_wdata[C_RDWR] || reg_wdata[C_WO]);

    // Hold the software-visible setup, transmit and accepted control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en  <= 1'b0;
            mask_wo <= 1'b0;
            mask_rw <= 1'b0;
            spare   <= '0;
            tx_lo   <= '0;
            tx_hi   <= '0;
            ctrl_q  <= '0;
            rd_mode <= 1'b0;
        end else begin
            if (reg_we) begin
                case (sel)
                    SEL_SETUP: begin
                        clk_en  <= reg_wdata[0];
                        mask_wo <= reg_wdata[4];
                        mask_rw <= reg_wdata[5];
                    end
                    SEL_SPARE: spare <= reg_wdata;
                    SEL_TXL:   tx_lo <= reg_wdata;
                    SEL_TXH:   tx_hi <= reg_wdata;
                    default: ;
                endcase
            end
            if (start) begin
                ctrl_q  <= reg_wdata[C_TOP:0];
                rd_mode <= reg_wdata[C_RDWR];
            end
        end
    end

    spim_shift #(.XFER_W(XFER_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_word({tx_hi, tx_lo}),
        .len_m1(reg_wdata[C_DEV-1:C_LEN]),
        .miso(miso), .sclk(sclk), .mosi(mosi),
        .busy(busy), .done(done), .rx_word(rx_word)
    );

    spim_csdec #(.NUM_CS(NUM_CS), .DEV_W(DEV_W)) u_cs (
        .active(busy), .dev(ctrl_q[C_TOP:C_DEV]), .cs_n(cs_n)
    );

    spim_status #(.SETTLE_CYC(SETTLE_CYC)) u_stat (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .rd_mode(rd_mode), .mask_wo(mask_wo), .mask_rw(mask_rw),
        .we_flag(we_flag), .re_flag(re_flag), .irq(irq)
    );

    // Select the register addressed for reading.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_SETUP: reg_rdata = HALF_W'({mask_rw, mask_wo, 3'b000, clk_en});
            SEL_SPARE: reg_rdata = spare;
            SEL_CTRL:  reg_rdata = HALF_W'(ctrl_q);
            SEL_STAT:  reg_rdata = HALF_W'({we_flag, re_flag});
            SEL_TXL:   reg_rdata = tx_lo;
            SEL_TXH:   reg_rdata = tx_hi;
            SEL_RXL:   reg_rdata = rx_word[HALF_W-1:0];
            SEL_RXH:   reg_rdata = rx_word[XFER_W-1:HALF_W];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_chk.sv
// Protocol checker for spim_ctrl: select exclusivity, idle clock, MOSI stability,
// settle interval and flag/interrupt consistency. Counts the settle gap itself.
module spim_chk #(
    parameter int NUM_CS     = 5,
    parameter int SETTLE_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              irq,
    input logic              busy,
    input logic              we_flag,
    input logic              re_flag
);
    localparam int GW = $clog2(SETTLE_CYC + 2) + 1;

    logic [GW-1:0] gap;

    // Count cycles since send-done was raised, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !we_flag) gap <= '0;
        else if (gap != GW'(SETTLE_CYC + 1)) gap <= gap + GW'(1);
    end

    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    p_idle_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == {NUM_CS{1'b1}}));
    p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    p_settle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_flag) |-> (gap == GW'(SETTLE_CYC)));
    p_re_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        re_flag |-> we_flag);
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (we_flag || re_flag));
endmodule

bind spim_ctrl spim_chk #(.NUM_CS(NUM_CS), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .irq(irq), .busy(busy), .we_flag(we_flag), .re_flag(re_flag)
);

// File: tb/sim_spim_ctrl.sv
// Self-checking bench for spim_ctrl: vector table of transfers, then directed cases.
module sim_spim_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 7;
    localparam int NVEC       = 7;
    // {len[5:0], dev[2:0], rdwr, tx[31:0], return pattern[31:0]}
    localparam logic [73:0] VEC [NVEC] = '{
        {6'd8,  3'd0, 1'b1, 32'hA500_0000, 32'h3C00_0000},
        {6'd1,  3'd1, 1'b1, 32'h8000_0000, 32'h8000_0000},
        {6'd32, 3'd2, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678},
        {6'd16, 3'd3, 1'b0, 32'hF00F_0000, 32'hFFFF_FFFF},
        {6'd13, 3'd4, 1'b1, 32'h6B38_0000, 32'hC3A5_0000},
        {6'd5,  3'd6, 1'b1, 32'hF800_0000, 32'hA800_0000},
        {6'd24, 3'd4, 1'b0, 32'h0F1E_2D00, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, mosi, miso, irq;
    logic [4:0]  cs_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] slv_pat = '0;
    logic        slv_ld = 1'b0;
    logic [31:0] slv;
    logic        mon_clr = 1'b0;
    logic [4:0]  cs_exp = 5'h1f;
    logic [31:0] mcap;
    int          nedge;
    logic        csbad;

    int          got_gap;
    logic [31:0] got_rx;
    logic        got_we, got_re, got_irq;

    spim_ctrl #(.NUM_CS(5), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Target model: presents pattern MSB first, advancing on SCLK falling edges.
    always @(negedge sclk or posedge slv_ld) begin
        if (slv_ld) slv <= slv_pat;
        else        slv <= {slv[30:0], 1'b0};
    end
    assign miso = slv[31];

    // Line monitor: captures MOSI and checks selects on each SCLK rising edge.
    always @(posedge sclk or posedge mon_clr) begin
        if (mon_clr) begin
            mcap <= '0; nedge <= 0; csbad <= 1'b0;
        end else begin
            mcap  <= {mcap[30:0], mosi};
            nedge <= nedge + 1;
            if (cs_n !== cs_exp) csbad <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input int len, input int dev, input logic [1:0] typ);
        return 16'({3'(dev), 5'(len - 1), typ});
    endfunction

    function automatic logic [4:0] sel_of(input int dev);
        return (dev < 5) ? ~(5'b1 << dev) : 5'h1f;
    endfunction

    // Run one transfer; poll status each cycle; record settle gap, flags and receive word.
    task automatic xfer(input int len, input int dev, input logic [1:0] typ,
                        input logic [31:0] tx, input logic [31:0] pat);
        logic [15:0] s, lo, hi;
        int nw, k;
        wr(4'h8, tx[15:0]);
        wr(4'hA, tx[31:16]);
        slv_pat = pat; slv_ld = 1'b1; #1 slv_ld = 1'b0;
        cs_exp = sel_of(dev);
        mon_clr = 1'b1; #1 mon_clr = 1'b0;
        wr(4'h4, ctrl_word(len, dev, typ));
        nw = -1; got_gap = -1; k = 0;
        while (k < 200) begin
            rd(4'h6, s);
            if (nw < 0 && s[1]) nw = k;
            if (s[0]) begin got_gap = k - nw; k = 200; end
            else if (nw >= 0 && (k - nw) > SETTLE + 3) k = 200;
            k++;
        end
        got_we = s[1]; got_re = s[0];
        #1 got_irq = irq;
        rd(4'hC, lo); rd(4'hE, hi);
        got_rx = {hi, lo};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [73:0] v;
        int len, dev;
        logic [31:0] emo, erx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 16; a += 2) begin
            rd(4'(a), d);
            chk("R1 reg reset", 32'(d), 32'h0);
        end
        chk("R1 cs_n idle", 32'(cs_n), 32'h1f);
        chk("R1 sclk/mosi/irq low", {29'h0, sclk, mosi, irq}, 32'h0);

        // R2: register readback
        wr(4'h0, 16'hFFFF); rd(4'h0, d); chk("R2 setup bits", 32'(d), 32'h31);
        wr(4'h2, 16'hBEEF); rd(4'h2, d); chk("R2 spare word", 32'(d), 32'hBEEF);
        wr(4'h8, 16'h1357); rd(4'h8, d); chk("R2 tx low", 32'(d), 32'h1357);
        wr(4'hA, 16'h9BDF); rd(4'hA, d); chk("R2 tx high", 32'(d), 32'h9BDF);

        // R9: start with clock disabled is ignored
        wr(4'h0, 16'h0000);
        mon_clr = 1'b1; #1 mon_clr = 1'b0;
        wr(4'h4, ctrl_word(8, 0, 2'b01));
        repeat (20) @(negedge clk);
        chk("R9 disabled no edges", 32'(nedge), 32'h0);
        rd(4'h6, d); chk("R9 disabled status", 32'(d), 32'h0);
        chk("R9 disabled selects", 32'(cs_n), 32'h1f);

        // Vector table: R3 R4 R5 R6 R7 R10
        wr(4'h0, 16'h0001);
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            len = int'(v[73:68]); dev = int'(v[67:65]);
            xfer(len, dev, v[64] ? 2'b01 : 2'b10, v[63:32], v[31:0]);
            emo = v[63:32] >> (32 - len);
            erx = v[31:0] >> (32 - len);
            chk("R4 bit count", 32'(nedge), 32'(len));
            chk("R4 mosi bits", mcap, emo);
            chk("R6 select during transfer", 32'(csbad), 32'h0);
            chk("R6 selects idle after", 32'(cs_n), 32'h1f);
            chk("R7 send done", 32'(got_we), 32'h1);
            if (v[64]) begin
                chk("R7 settle gap", 32'(got_gap), 32'(SETTLE));
                chk("R5 receive word", got_rx, erx);
            end else begin
                chk("R7 no receive done on send-only", 32'(got_re), 32'h0);
            end
            chk("R10 irq unmasked", 32'(got_irq), 32'h1);
        end

        // R3: both type bits set behaves as send-and-receive
        xfer(4, 1, 2'b11, 32'hA000_0000, 32'h5000_0000);
        chk("R3 both bits receive done", 32'(got_re), 32'h1);
        chk("R3 both bits rx", got_rx, 32'h5);
        rd(4'h4, d); chk("R3 ctrl readback", 32'(d), 32'(ctrl_word(4, 1, 2'b11) & 16'h3FF));

        // R9 busy / R8 status clear
        wr(4'h8, 16'h0000); wr(4'hA, 16'hC300);
        slv_pat = 32'h9600_0000; slv_ld = 1'b1; #1 slv_ld = 1'b0;
        cs_exp = sel_of(0);
        mon_clr = 1'b1; #1 mon_clr = 1'b0;
        wr(4'h4, ctrl_word(8, 0, 2'b01));
        rd(4'h6, d); chk("R8 status cleared on start", 32'(d), 32'h0);
        #1 chk("R10 irq low after start", 32'(irq), 32'h0);
        wr(4'h4, ctrl_word(32, 1, 2'b10));
        repeat (40) @(negedge clk);
        chk("R9 busy write edges", 32'(nedge), 32'd8);
        chk("R9 busy write select", 32'(csbad), 32'h0);
        chk("R9 busy write mosi", mcap, 32'hC3);
        rd(4'h6, d); chk("R9 busy write status", 32'(d), 32'h3);
        rd(4'hC, d); chk("R9 busy write rx", 32'(d), 32'h96);

        // R10: masks
        wr(4'h0, 16'h0021);
        xfer(3, 2, 2'b01, 32'hE000_0000, 32'h0);
        chk("R10 rw masked", 32'(got_irq), 32'h0);
        chk("R10 rw masked flag still set", 32'(got_re), 32'h1);
        xfer(3, 2, 2'b10, 32'hE000_0000, 32'h0);
        chk("R10 rw mask no effect on send-only", 32'(got_irq), 32'h1);
        wr(4'h0, 16'h0011);
        xfer(3, 2, 2'b10, 32'hE000_0000, 32'h0);
        chk("R10 wo masked", 32'(got_irq), 32'h0);
        xfer(3, 2, 2'b01, 32'hE000_0000, 32'h0);
        chk("R10 wo mask no effect on rw", 32'(got_irq), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule